// File: doc/BRIEF.md
# Sleep-Aware System Clock Controller

This block is the control side of a microcontroller clock generator. It picks which of four oscillators (internal, slow crystal, fast crystal, external) drives the system clock, and it produces a clock-enable pulse that divides that source by 1, 2, 4 or 8. The oscillators are modelled as handshakes: the block asserts an enable for each one and watches its ready flag. The actual clock multiplexing cells are outside this block. Everything runs on one reference clock, and each enable pulse stands for one period of the divided source.

The CPU requests sleep through a strobe, and an interrupt line wakes the block. When sleep is entered, each oscillator is stopped or left running according to its own stop-in-sleep bit. On wake-up the block either resumes the previous source and divider, or it loads a separate wake-up source and divider into the clock-select register. The system clock stays gated until the chosen oscillator reports ready. A source change in run mode first turns on the new oscillator and switches over only once it is ready. The clock-select register can be written only after a 16-bit key has unlocked it.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the active source is 0 (internal), only `osc_en[0]` is set, the lock reads 1, and `sys_run` stays 0 until `osc_ready[0]` is seen. After that it becomes 1.
- R2: Writing 0x0096 to address 0 clears the lock and writing any other value sets it. Reading address 0 returns the lock in bit 0.
- R3: While the lock is set, writes to the clock-select register (address 1) leave its read-back value unchanged.
- R4: Clock-select layout is source [1:0], divider [5:4], wake source [9:8], wake divider [13:12] and wake enable [15]. In run mode, divider codes 0, 1, 2 and 3 give one `sys_ce` pulse every 1, 2, 4 and 8 cycles.
- R5: A new source written in run mode sets that oscillator's enable within one cycle. `sys_src` takes the new code only after the oscillator's ready input is high.
- R6: A `sleep_req` in run mode enters sleep. In sleep `sys_run` and `sys_ce` are 0, and every oscillator whose bit is set in the stop mask (address 2, bit i for source i) loses its enable, while the others keep theirs.
- R7: With wake enable 0, a `wake_irq` in sleep resumes the source and divider that were active before sleep.
- R8: With wake enable 1, a wake-up copies the wake source and wake divider into the source and divider fields, and `sys_src` follows.
- R9: After wake-up, `sys_run` and `sys_ce` stay 0 until the chosen oscillator's ready input is high. If that oscillator was kept running, run mode returns on the second cycle.
- R10: `sleep_req` outside run mode and `wake_irq` outside sleep have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 key/lock, 1 clock select, 2 stop mask) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| sleep_req | input | 1 | Sleep request from the CPU |
| wake_irq | input | 1 | Wake-up interrupt |
| osc_ready | input | 4 | Per-oscillator stable flag |
| osc_en | output | 4 | Per-oscillator enable |
| sys_src | output | 2 | Active source code |
| sys_ce | output | 1 | Divided system clock enable |
| sys_run | output | 1 | High in run mode |

## Verification
The assertions assume that an oscillator's ready flag rises only while its enable is high, and then stays high until the enable drops. They also assume that reset is held for at least two cycles. The bench meets both assumptions with its own oscillator models, one per source, each with a different start-up delay: ready rises a fixed number of cycles after enable and clears as soon as enable falls. Stimulus covers both wake-up modes, a stopped and a kept-running wake source, and stray sleep and wake strobes in the wrong mode.

// File: rtl/clkctl_pkg.sv
// Shared types and constants of the system clock controller.
package clkctl_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAIT  = 2'd2
    } pstate_e;

    localparam logic [1:0]  ADDR_KEY  = 2'd0;
    localparam logic [1:0]  ADDR_CSEL = 2'd1;
    localparam logic [1:0]  ADDR_STOP = 2'd2;
    localparam logic [15:0] UNLOCK_KEY = 16'h0096;

    localparam int SRC_LSB  = 0;
    localparam int DIV_LSB  = 4;
    localparam int WSRC_LSB = 8;
    localparam int WDIV_LSB = 12;
    localparam int WEN_BIT  = 15;
endpackage

// File: rtl/clkctl_regs.sv
// Register file: key lock, clock-select and stop-in-sleep mask.
// Assumes SW and DVW are at most 2 so the fields fit the 16-bit layout.
// A wake load with wake enable set overrides a same-cycle write.
module clkctl_regs
    import clkctl_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int SW   = 2,
    parameter int DVW  = 2,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic            wake_load,
    output logic [SW-1:0]   cfg_src,
    output logic [DVW-1:0]  cfg_div,
    output logic [SW-1:0]   wup_src,
    output logic [DVW-1:0]  wup_div,
    output logic            wup_en,
    output logic [NSRC-1:0] stop_mask
);
    logic locked;
    logic csel_wr;

    assign csel_wr = wr_en && (addr == ADDR_CSEL) && !locked;

    // Lock flag follows the last value written to the key address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b1;
        else if (wr_en && addr == ADDR_KEY)
            locked <= (wdata != UNLOCK_KEY);
    end

    // Clock-select fields: protected writes, wake-up copy takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_src <= '0;
            cfg_div <= '0;
            wup_src <= '0;
            wup_div <= '0;
            wup_en  <= 1'b0;
        end else begin
            if (csel_wr) begin
                cfg_src <= wdata[SRC_LSB  +: SW];
                cfg_div <= wdata[DIV_LSB  +: DVW];
                wup_src <= wdata[WSRC_LSB +: SW];
                wup_div <= wdata[WDIV_LSB +: DVW];
                wup_en  <= wdata[WEN_BIT];
            end
            if (wake_load && wup_en) begin
                cfg_src <= wup_src;
                cfg_div <= wup_div;
            end
        end
    end

    // Stop-in-sleep mask, not protected.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_mask <= '0;
        else if (wr_en && addr == ADDR_STOP)
            stop_mask <= wdata[NSRC-1:0];
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_KEY:  rdata[0] = locked;
            ADDR_CSEL: begin
                rdata[SRC_LSB  +: SW]  = cfg_src;
                rdata[DIV_LSB  +: DVW] = cfg_div;
                rdata[WSRC_LSB +: SW]  = wup_src;
                rdata[WDIV_LSB +: DVW] = wup_div;
                rdata[WEN_BIT]         = wup_en;
            end
            ADDR_STOP: rdata[NSRC-1:0] = stop_mask;
            default:   rdata = '0;
        endcase
    end

    // R2
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == ADDR_KEY && wdata != UNLOCK_KEY) |-> locked);

    // R3
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == ADDR_CSEL && locked && !wake_load)
        |-> ($stable(cfg_src) && $stable(cfg_div) && $stable(wup_en)));
endmodule

// File: rtl/clkctl_fsm.sv
// Power-mode sequencer: run, sleep and wake-wait. It owns the oscillator
// enables and the active source. Assumes a ready flag rises only while its
// enable is high and stays high until the enable drops.
module clkctl_fsm
    import clkctl_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int SW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic            wake_irq,
    input  logic [NSRC-1:0] osc_ready,
    input  logic [SW-1:0]   cfg_src,
    input  logic [SW-1:0]   wup_src,
    input  logic            wup_en,
    input  logic [NSRC-1:0] stop_mask,
    output logic [NSRC-1:0] osc_en,
    output logic [SW-1:0]   act_src,
    output logic            run,
    output logic            wake_load
);
    pstate_e         st;
    logic [NSRC-1:0] osc_on;
    logic [SW-1:0]   wake_src;

    assign wake_load = (st == ST_SLEEP) && wake_irq;
    assign wake_src  = wup_en ? wup_src : act_src;
    assign run       = (st == ST_RUN);
    assign osc_en    = osc_on;

    // Mode transitions, source handover and oscillator enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_WAIT;
            act_src <= '0;
            osc_on  <= NSRC'(1);
        end else begin
            case (st)
                ST_WAIT: if (osc_ready[act_src]) st <= ST_RUN;
                ST_RUN: begin
                    if (sleep_req) begin
                        st     <= ST_SLEEP;
                        osc_on <= osc_on & ~stop_mask;
                    end else if (cfg_src != act_src) begin
                        osc_on[cfg_src] <= 1'b1;
                        if (osc_ready[cfg_src]) act_src <= cfg_src;
                    end
                end
                ST_SLEEP: if (wake_irq) begin
                    act_src          <= wake_src;
                    osc_on[wake_src] <= 1'b1;
                    st               <= ST_WAIT;
                end
                default: st <= ST_WAIT;
            endcase
        end
    end

    // R5
    run_src_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> osc_en[act_src]);

    // R5
    switch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_src != $past(act_src) && $past(st) == ST_RUN) |-> $past(osc_ready[act_src]));

    // R9
    wake_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && $past(st) == ST_WAIT) |-> $past(osc_ready[act_src]));
endmodule

// File: rtl/clkctl_div.sv
// Power-of-two divider that makes a clock-enable pulse every 2**div cycles
// while running. The count restarts outside run mode, and a count above a
// smaller new limit wraps at once.
module clkctl_div #(
    parameter int DVW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_i,
    input  logic [DVW-1:0] div_i,
    output logic           ce_o
);
    localparam int CW = (1 << DVW) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = CW'((32'd1 << div_i) - 32'd1);
    assign ce_o = run_i && (cnt >= lim);

    // Cycle counter within one divided period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (run_i && cnt < lim)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    // R4
    ce_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_o && $past(ce_o) && $past(run_i) && $stable(div_i)) |-> (div_i == '0));
endmodule

// File: rtl/sysclk_ctrl.sv
// Top of the sleep-aware system clock controller: register file, power-mode
// sequencer and divider. Assumes oscillator ready flags behave as a
// handshake on osc_en.
module sysclk_ctrl #(
    parameter int NSRC = 4,
    parameter int DVW  = 2,
    parameter int DW   = 16,
    localparam int SW  = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            sleep_req,
    input  logic            wake_irq,
    input  logic [NSRC-1:0] osc_ready,
    output logic [NSRC-1:0] osc_en,
    output logic [SW-1:0]   sys_src,
    output logic            sys_ce,
    output logic            sys_run
);
    logic [SW-1:0]   cfg_src, wup_src;
    logic [DVW-1:0]  cfg_div, wup_div;
    logic            wup_en, wake_load;
    logic [NSRC-1:0] stop_mask;

    clkctl_regs #(.NSRC(NSRC), .SW(SW), .DVW(DVW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .wake_load(wake_load),
        .cfg_src(cfg_src), .cfg_div(cfg_div), .wup_src(wup_src),
        .wup_div(wup_div), .wup_en(wup_en), .stop_mask(stop_mask)
    );

    clkctl_fsm #(.NSRC(NSRC), .SW(SW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_irq(wake_irq),
        .osc_ready(osc_ready), .cfg_src(cfg_src), .wup_src(wup_src),
        .wup_en(wup_en), .stop_mask(stop_mask), .osc_en(osc_en),
        .act_src(sys_src), .run(sys_run), .wake_load(wake_load)
    );

    clkctl_div #(.DVW(DVW)) u_div (
        .clk(clk), .rst_n(rst_n), .run_i(sys_run), .div_i(cfg_div), .ce_o(sys_ce)
    );

    // R6
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_run |-> !sys_ce);
endmodule

// File: tb/tb_sysclk_ctrl.sv
module tb_sysclk_ctrl;
    localparam int PERIOD = 10;
    localparam int STAB [4] = '{3, 5, 7, 4};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        sleep_req = 1'b0;
    logic        wake_irq = 1'b0;
    logic [3:0]  osc_ready;
    logic [3:0]  osc_en;
    logic [1:0]  sys_src;
    logic        sys_ce;
    logic        sys_run;

    int checks = 0;
    int errors = 0;
    int ocnt [4] = '{0, 0, 0, 0};

    sysclk_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
        .wake_irq(wake_irq), .osc_ready(osc_ready), .osc_en(osc_en),
        .sys_src(sys_src), .sys_ce(sys_ce), .sys_run(sys_run)
    );

    always #(PERIOD/2) clk = ~clk;

    // Oscillator models: ready a fixed delay after enable, cleared when disabled.
    always @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (osc_en[i] !== 1'b1) ocnt[i] <= 0;
            else if (ocnt[i] < STAB[i]) ocnt[i] <= ocnt[i] + 1;
        end
    end
    always_comb begin
        for (int i = 0; i < 4; i++) osc_ready[i] = (ocnt[i] == STAB[i]);
    end

    // Behavioural reference model (0 run, 1 sleep, 2 wait).
    int m_st, m_act, m_cnt, m_src, m_div, m_wsrc, m_wdiv, m_wen, m_lock, m_stop, m_on;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 2; m_act = 0; m_cnt = 0; m_src = 0; m_div = 0;
            m_wsrc = 0; m_wdiv = 0; m_wen = 0; m_lock = 1; m_stop = 0; m_on = 1;
        end else begin
            int n_st, n_act, n_on, n_cnt, tgt, lim;
            int o_lock, o_wen, o_wsrc, o_wdiv;
            bit wake;
            wake = (m_st == 1) && wake_irq;
            lim = (1 << m_div) - 1;
            n_cnt = (m_st == 0 && m_cnt < lim) ? m_cnt + 1 : 0;
            n_st = m_st; n_act = m_act; n_on = m_on;
            if (m_st == 2) begin
                if (osc_ready[m_act]) n_st = 0;
            end else if (m_st == 0) begin
                if (sleep_req) begin
                    n_st = 1; n_on = m_on & ~m_stop;
                end else if (m_src != m_act) begin
                    n_on = m_on | (1 << m_src);
                    if (osc_ready[m_src]) n_act = m_src;
                end
            end else if (wake) begin
                tgt = m_wen ? m_wsrc : m_act;
                n_act = tgt; n_on = m_on | (1 << tgt); n_st = 2;
            end
            o_lock = m_lock; o_wen = m_wen; o_wsrc = m_wsrc; o_wdiv = m_wdiv;
            if (reg_wr && reg_addr == 2'd0) m_lock = (reg_wdata != 16'h0096);
            if (reg_wr && reg_addr == 2'd1 && o_lock == 0) begin
                m_src = reg_wdata[1:0]; m_div = reg_wdata[5:4];
                m_wsrc = reg_wdata[9:8]; m_wdiv = reg_wdata[13:12]; m_wen = reg_wdata[15];
            end
            if (reg_wr && reg_addr == 2'd2) m_stop = reg_wdata[3:0];
            if (wake && o_wen == 1) begin
                m_src = o_wsrc; m_div = o_wdiv;
            end
            m_st = n_st; m_act = n_act; m_on = n_on; m_cnt = n_cnt;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 sys_ce", int'(sys_ce),
                int'(m_st == 0 && m_cnt >= ((1 << m_div) - 1)));
            chk("R5 sys_src", int'(sys_src), m_act);
            chk("R6 osc_en", int'(osc_en), m_on);
            chk("R9 sys_run", int'(sys_run), int'(m_st == 0));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic pulse_sleep();
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_irq = 1'b1;
        @(negedge clk); wake_irq = 1'b0;
    endtask

    task automatic count_ce(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (sys_ce) c++;
        end
    endtask

    bit done = 1'b0;

    initial begin
        int v, c;
        tick(3);
        chk("R1 src after reset", int'(sys_src), 0);
        chk("R1 osc_en after reset", int'(osc_en), 1);
        chk("R1 gated in reset", int'(sys_run), 0);
        rst_n = 1'b1;
        rd(2'd0, v); chk("R1 lock after reset", v, 1);
        tick(8);
        chk("R1 run after internal ready", int'(sys_run), 1);

        wr(2'd1, 16'h0002);
        rd(2'd1, v); chk("R3 locked write ignored", v, 0);
        wr(2'd0, 16'h0096);
        rd(2'd0, v); chk("R2 unlocked", v, 0);
        wr(2'd0, 16'h1234);
        rd(2'd0, v); chk("R2 relocked", v, 1);
        wr(2'd0, 16'h0096);

        wr(2'd1, 16'h0020); tick(8);
        count_ce(16, c); chk("R4 div4", c, 4);
        wr(2'd1, 16'h0030); tick(8);
        count_ce(16, c); chk("R4 div8", c, 2);
        wr(2'd1, 16'h0010); tick(4);
        count_ce(16, c); chk("R4 div2", c, 8);
        wr(2'd1, 16'h0000); tick(4);
        count_ce(8, c); chk("R4 div1", c, 8);

        wr(2'd1, 16'h0001);
        chk("R5 src held before ready", int'(sys_src), 0);
        tick(1);
        chk("R5 target enabled", int'(osc_en[1]), 1);
        tick(20);
        chk("R5 switched", int'(sys_src), 1);

        pulse_wake(); tick(1);
        chk("R10 wake ignored in run", int'(sys_run), 1);

        wr(2'd2, 16'h0001);
        pulse_sleep();
        chk("R6 sleeping", int'(sys_run), 0);
        chk("R6 stop mask", int'(osc_en), 2);
        count_ce(8, c); chk("R6 no ce in sleep", c, 0);
        pulse_sleep(); tick(1);
        chk("R10 sleep ignored in sleep", int'(sys_run), 0);
        chk("R10 enables kept", int'(osc_en), 2);

        pulse_wake(); tick(1);
        chk("R9 fast resume", int'(sys_run), 1);
        chk("R7 same source", int'(sys_src), 1);
        rd(2'd1, v); chk("R7 csel kept", v, 16'h0001);

        wr(2'd1, 16'h9001);
        wr(2'd2, 16'h0002);
        pulse_sleep();
        chk("R6 all stopped", int'(osc_en), 0);
        pulse_wake(); tick(1);
        chk("R9 gated until ready", int'(sys_run), 0);
        chk("R8 wake source enabled", int'(osc_en), 1);
        tick(10);
        chk("R9 run after ready", int'(sys_run), 1);
        chk("R8 wake source active", int'(sys_src), 0);
        rd(2'd1, v); chk("R8 fields copied", v, 16'h9010);
        tick(4);
        count_ce(16, c); chk("R8 wake divider", c, 8);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule